// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This unit holds the payload of block-data transfers and I2C-style block reads on a host-side SMBus controller. It has a 32-entry byte array, an index, a byte count, a single holding byte and an operation-finished flag. It also owns the four status bits that these transfers touch: busy, interrupt, device error and byte-done. Software reaches it through a block-data port, a count register, write-1-to-clear status strobes and a start strobe. The bus sequencer is told to send the buffered block, to run a block read, or to hand over the next received byte. Bus signalling itself lives in the sequencer.

The unit works in one of two modes. In buffered mode (`buf_mode`=1), software fills the whole array before a write, or drains it after a read, through the block-data port. In byte-by-byte mode, each byte passes through the holding register. Software paces the transfer by clearing byte-done. The last-byte control input ends a read, and for an I2C block read it asks the sequencer to NACK the final byte and stop.

In any one cycle only one request is acted on, in this order: start, sequencer read completion, byte-done advance, block-data write, block-data read. A count write and a sequencer fill always take effect. A fill wins the array write port over the control path.

Top module: `smbb_xfer_buf`

## Requirements
- R1: In buffered mode a block-data write stores the byte at the current index and then increments the index. In byte mode it loads the holding byte instead, and `bd_rdata` then returns the holding byte.
- R2: The index ranges over 0..32. A buffered access at index 32 first wraps the index to 0, so a 33rd buffered write lands in entry 0. A byte-done advance wraps eagerly from 31 to 0.
- R3: A buffered block write (`go_kind`=0) checks that the index equals the count. On a mismatch it sets device error and resets the index, with no send request. On a match it pulses `seq_wr_req`, sets interrupt, clears busy and resets the index.
- R4: A block read (`go_kind`=1) pulses `seq_rd_req` and sets busy. On `rd_done` the count takes `rd_count` and the index resets. In buffered mode interrupt is then set, and each block-data read returns the next entry. The read of the last counted entry clears busy, sets `op_idle` and resets the index.
- R5: In byte mode a block write start copies the holding byte into entry 0 and sets busy and byte-done. A block read completion presents entry 0 in the holding byte. An I2C block read start (`go_kind`=2) fetches the first byte from the sequencer in the same cycle.
- R6: In byte mode, clearing byte-done on a write advances the index. When the new index equals the count, it pulses `seq_wr_req`, sets interrupt and clears busy. Otherwise it stores the holding byte at the new index and sets byte-done again.
- R7: On a byte-mode read advance, the next byte is loaded into the holding register. With `last_byte` set, the advance also sets interrupt, clears busy, resets the index and ends the operation; for an I2C block read it pulses `seq_fetch` together with `seq_last`. Without `last_byte`, byte-done is set again.
- R8: A start while an operation is unfinished resets the index and marks the operation done before the new transfer runs. If an I2C block read was open, the start also pulses `seq_end`.
- R9: While device error is set, a start issues no sequencer request and leaves busy and the other status bits as they are.
- R10: `clr_mask` bit 0 clears interrupt, bit 1 clears device error and bit 2 clears byte-done. Busy cannot be cleared. Clearing byte-done advances a transfer only while a byte-by-byte operation is unfinished.
- R11: After reset all status bits, the index, the count and the holding byte are zero, and `op_idle` is 1.
- R12: A start with `go_kind`=3 sets device error and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_mode | input | 1 | 1 selects buffered mode |
| last_byte | input | 1 | Marks the next read advance as final |
| go | input | 1 | Start strobe |
| go_kind | input | 2 | 0 block write, 1 block read, 2 I2C block read |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 6 | Count value |
| cnt_q | output | 6 | Current count |
| bd_wr | input | 1 | Block-data port write strobe |
| bd_wdata | input | 8 | Block-data write byte |
| bd_rd | input | 1 | Block-data port read strobe |
| bd_rdata | output | 8 | Block-data read byte |
| clr_en | input | 1 | Status clear strobe |
| clr_mask | input | 3 | {byte-done, device error, interrupt} to clear |
| st_busy | output | 1 | Busy status |
| st_intr | output | 1 | Interrupt status |
| st_derr | output | 1 | Device error status |
| st_bdone | output | 1 | Byte-done status |
| op_idle | output | 1 | Operation finished |
| seq_wr_req | output | 1 | Request to send the buffered block |
| seq_rd_req | output | 1 | Request to run a block read |
| seq_fetch | output | 1 | Takes `seq_fetch_data` this cycle |
| seq_last | output | 1 | With `seq_fetch`: NACK this byte and stop |
| seq_end | output | 1 | Abandon the open I2C block read |
| seq_fetch_data | input | 8 | Next received byte from the sequencer |
| fill_we | input | 1 | Sequencer write into the array |
| fill_idx | input | 5 | Array entry for the sequencer write |
| fill_data | input | 8 | Byte for the sequencer write |
| rd_done | input | 1 | Block read completed |
| rd_count | input | 6 | Byte count returned by the read |
| seq_raddr | input | 5 | Array entry the sequencer reads |
| seq_rdata | output | 8 | Array byte at `seq_raddr` |

## Verification
The bench targets the index boundaries. A full 32-byte buffered write must match a count of 32 before wrapping, and the 33rd write must land in entry 0. A design that wrapped eagerly would raise device error on a valid full block, or overwrite the wrong entry. The bench clears byte-done when no byte-by-byte operation is open, and when the count is reached on the very advance; a design that advanced anyway would move the index or emit a spurious send. The bench also starts a new transfer while an I2C block read is open, which must reset the index and pulse `seq_end`. Finally, it starts with device error set, where a design that ignored the error would issue bus requests.

// File: rtl/smbb_pkg.sv
package smbb_pkg;

  typedef enum logic [1:0] {
    XK_WRITE    = 2'd0,
    XK_READ     = 2'd1,
    XK_I2C_READ = 2'd2,
    XK_BAD      = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic busy;
    logic intr;
    logic derr;
    logic bdone;
  } stat_t;

endpackage

// File: rtl/smbb_store.sv
module smbb_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int NRD   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rport
    assign rdata[g*DW +: DW] = mem[raddr[g*AW +: AW]];
  end

endmodule

// File: rtl/smbb_ctrl.sv
module smbb_ctrl
  import smbb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode,
  input  logic          last_byte,
  input  logic          go,
  input  logic [1:0]    go_kind,
  input  logic          cnt_we,
  input  logic [IW-1:0] cnt_wdata,
  input  logic          bd_wr,
  input  logic [DW-1:0] bd_wdata,
  input  logic          bd_rd,
  input  logic          clr_en,
  input  logic [2:0]    clr_mask,
  input  logic          rd_done,
  input  logic [IW-1:0] rd_count,
  input  logic [DW-1:0] seq_fetch_data,
  input  logic [DW-1:0] port_rd,
  input  logic [DW-1:0] adv_rd,
  input  logic [DW-1:0] head_rd,
  output logic [AW-1:0] port_ra,
  output logic [AW-1:0] adv_ra,
  output logic          c_we,
  output logic [AW-1:0] c_wa,
  output logic [DW-1:0] c_wd,
  output logic [DW-1:0] bd_rdata,
  output logic [IW-1:0] cnt_q,
  output stat_t         stat_q,
  output logic          op_idle,
  output logic          seq_wr_req,
  output logic          seq_rd_req,
  output logic          seq_fetch,
  output logic          seq_last,
  output logic          seq_end,
  output logic [IW-1:0] idx_q
);

  localparam logic [IW-1:0] DEPTH_I = IW'(DEPTH);
  localparam logic [IW-1:0] ONE_I   = IW'(1);

  logic [IW-1:0] idx_d, cnt_d;
  logic [DW-1:0] hold_q, hold_d;
  stat_t         stat_d;
  logic          opd_q, opd_d, i2c_q, i2c_d, dir_q, dir_d, rdw_q, rdw_d;

  logic [IW-1:0] eff_idx, step_idx, adv_raw, adv_idx, base_idx;
  logic          serial_on, clr_bd, rd_dir, upd_en;
  xfer_kind_e    kind;

  assign kind      = xfer_kind_e'(go_kind);
  assign eff_idx   = (idx_q >= DEPTH_I) ? '0 : idx_q;
  assign step_idx  = eff_idx + ONE_I;
  assign adv_raw   = idx_q + ONE_I;
  assign adv_idx   = (adv_raw >= DEPTH_I) ? '0 : adv_raw;
  assign base_idx  = opd_q ? idx_q : '0;
  assign serial_on = !opd_q && (i2c_q || !buf_mode);
  assign clr_bd    = clr_en && clr_mask[2] && stat_q.bdone;
  assign rd_dir    = i2c_q || dir_q;
  assign port_ra   = eff_idx[AW-1:0];
  assign adv_ra    = adv_idx[AW-1:0];
  assign bd_rdata  = (buf_mode && !i2c_q) ? port_rd : hold_q;
  assign op_idle   = opd_q;
  assign upd_en    = go | rd_done | clr_en | bd_wr | bd_rd | cnt_we;

  always_comb begin
    idx_d      = idx_q;
    cnt_d      = cnt_we ? cnt_wdata : cnt_q;
    hold_d     = hold_q;
    opd_d      = opd_q;
    i2c_d      = i2c_q;
    dir_d      = dir_q;
    rdw_d      = rdw_q;
    stat_d     = stat_q;
    c_we       = 1'b0;
    c_wa       = '0;
    c_wd       = hold_q;
    seq_wr_req = 1'b0;
    seq_rd_req = 1'b0;
    seq_fetch  = 1'b0;
    seq_last   = 1'b0;
    seq_end    = 1'b0;
    if (clr_en) begin
      stat_d.intr  = stat_q.intr  & ~clr_mask[0];
      stat_d.derr  = stat_q.derr  & ~clr_mask[1];
      stat_d.bdone = stat_q.bdone & ~clr_mask[2];
    end

    if (go) begin
      rdw_d = 1'b0;
      dir_d = (kind != XK_WRITE);
      if (!opd_q) begin
        idx_d = '0;
        opd_d = 1'b1;
        if (i2c_q) begin
          i2c_d   = 1'b0;
          seq_end = 1'b1;
        end
      end
      if (!stat_q.derr) begin
        unique case (kind)
          XK_WRITE: begin
            if (buf_mode) begin
              idx_d = '0;
              if (base_idx != cnt_q) begin
                stat_d.derr = 1'b1;
              end else begin
                seq_wr_req  = 1'b1;
                opd_d       = 1'b1;
                stat_d.intr = 1'b1;
                stat_d.busy = 1'b0;
              end
            end else begin
              c_we         = 1'b1;
              c_wa         = '0;
              idx_d        = '0;
              opd_d        = 1'b0;
              stat_d.busy  = 1'b1;
              stat_d.bdone = 1'b1;
            end
          end
          XK_READ: begin
            seq_rd_req  = 1'b1;
            rdw_d       = 1'b1;
            stat_d.busy = 1'b1;
          end
          XK_I2C_READ: begin
            seq_fetch    = 1'b1;
            hold_d       = seq_fetch_data;
            i2c_d        = 1'b1;
            opd_d        = 1'b0;
            stat_d.busy  = 1'b1;
            stat_d.bdone = 1'b1;
          end
          default: stat_d.derr = 1'b1;
        endcase
      end
    end else if (rd_done && rdw_q) begin
      rdw_d = 1'b0;
      cnt_d = rd_count;
      idx_d = '0;
      opd_d = 1'b0;
      if (buf_mode) begin
        stat_d.intr = 1'b1;
      end else begin
        hold_d       = head_rd;
        stat_d.bdone = 1'b1;
      end
    end else if (clr_bd && serial_on) begin
      if (!rd_dir) begin
        idx_d = adv_idx;
        if (adv_idx == cnt_q) begin
          seq_wr_req  = 1'b1;
          opd_d       = 1'b1;
          stat_d.intr = 1'b1;
          stat_d.busy = 1'b0;
        end else begin
          c_we         = 1'b1;
          c_wa         = adv_idx[AW-1:0];
          stat_d.bdone = 1'b1;
        end
      end else begin
        if (i2c_q) begin
          seq_fetch = 1'b1;
          hold_d    = seq_fetch_data;
        end else begin
          hold_d = adv_rd;
        end
        if (last_byte) begin
          seq_last    = i2c_q;
          i2c_d       = 1'b0;
          opd_d       = 1'b1;
          idx_d       = '0;
          stat_d.intr = 1'b1;
          stat_d.busy = 1'b0;
        end else begin
          idx_d        = adv_idx;
          stat_d.bdone = 1'b1;
        end
      end
    end else if (bd_wr) begin
      if (buf_mode) begin
        c_we  = 1'b1;
        c_wa  = eff_idx[AW-1:0];
        c_wd  = bd_wdata;
        idx_d = step_idx;
      end else begin
        hold_d = bd_wdata;
      end
    end else if (bd_rd) begin
      if (buf_mode && !i2c_q) begin
        idx_d = step_idx;
        if (!opd_q && step_idx == cnt_q) begin
          idx_d       = '0;
          opd_d       = 1'b1;
          stat_d.busy = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      stat_q <= '0;
      opd_q  <= 1'b1;
      i2c_q  <= 1'b0;
      dir_q  <= 1'b0;
      rdw_q  <= 1'b0;
    end else if (upd_en) begin
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      stat_q <= stat_d;
      opd_q  <= opd_d;
      i2c_q  <= i2c_d;
      dir_q  <= dir_d;
      rdw_q  <= rdw_d;
    end
  end

endmodule

// File: rtl/smbb_xfer_buf.sv
module smbb_xfer_buf
  import smbb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode,
  input  logic          last_byte,
  input  logic          go,
  input  logic [1:0]    go_kind,
  input  logic          cnt_we,
  input  logic [IW-1:0] cnt_wdata,
  output logic [IW-1:0] cnt_q,
  input  logic          bd_wr,
  input  logic [DW-1:0] bd_wdata,
  input  logic          bd_rd,
  output logic [DW-1:0] bd_rdata,
  input  logic          clr_en,
  input  logic [2:0]    clr_mask,
  output logic          st_busy,
  output logic          st_intr,
  output logic          st_derr,
  output logic          st_bdone,
  output logic          op_idle,
  output logic          seq_wr_req,
  output logic          seq_rd_req,
  output logic          seq_fetch,
  output logic          seq_last,
  output logic          seq_end,
  input  logic [DW-1:0] seq_fetch_data,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_idx,
  input  logic [DW-1:0] fill_data,
  input  logic          rd_done,
  input  logic [IW-1:0] rd_count,
  input  logic [AW-1:0] seq_raddr,
  output logic [DW-1:0] seq_rdata
);

  localparam int NRD = 4;

  logic [AW-1:0]     port_ra, adv_ra, c_wa, m_wa;
  logic [DW-1:0]     c_wd, m_wd;
  logic              c_we, m_we;
  logic [NRD*AW-1:0] m_ra;
  logic [NRD*DW-1:0] m_rd;
  logic [IW-1:0]     idx_q;
  stat_t             stat_q;

  assign m_we = fill_we | c_we;
  assign m_wa = fill_we ? fill_idx  : c_wa;
  assign m_wd = fill_we ? fill_data : c_wd;
  assign m_ra = {seq_raddr, {AW{1'b0}}, adv_ra, port_ra};

  assign st_busy   = stat_q.busy;
  assign st_intr   = stat_q.intr;
  assign st_derr   = stat_q.derr;
  assign st_bdone  = stat_q.bdone;
  assign seq_rdata = m_rd[3*DW +: DW];

  smbb_store #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) u_store (
    .clk   (clk),
    .we    (m_we),
    .waddr (m_wa),
    .wdata (m_wd),
    .raddr (m_ra),
    .rdata (m_rd)
  );

  smbb_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .buf_mode       (buf_mode),
    .last_byte      (last_byte),
    .go             (go),
    .go_kind        (go_kind),
    .cnt_we         (cnt_we),
    .cnt_wdata      (cnt_wdata),
    .bd_wr          (bd_wr),
    .bd_wdata       (bd_wdata),
    .bd_rd          (bd_rd),
    .clr_en         (clr_en),
    .clr_mask       (clr_mask),
    .rd_done        (rd_done),
    .rd_count       (rd_count),
    .seq_fetch_data (seq_fetch_data),
    .port_rd        (m_rd[0 +: DW]),
    .adv_rd         (m_rd[DW +: DW]),
    .head_rd        (m_rd[2*DW +: DW]),
    .port_ra        (port_ra),
    .adv_ra         (adv_ra),
    .c_we           (c_we),
    .c_wa           (c_wa),
    .c_wd           (c_wd),
    .bd_rdata       (bd_rdata),
    .cnt_q          (cnt_q),
    .stat_q         (stat_q),
    .op_idle        (op_idle),
    .seq_wr_req     (seq_wr_req),
    .seq_rd_req     (seq_rd_req),
    .seq_fetch      (seq_fetch),
    .seq_last       (seq_last),
    .seq_end        (seq_end),
    .idx_q          (idx_q)
  );

endmodule

// File: rtl/smbb_xfer_buf_chk.sv
module smbb_xfer_buf_chk #(
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          st_derr,
  input logic          st_intr,
  input logic          st_busy,
  input logic          op_idle,
  input logic          seq_wr_req,
  input logic          seq_rd_req,
  input logic          seq_fetch,
  input logic          seq_last,
  input logic          seq_end,
  input logic [IW-1:0] idx_q
);

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(DEPTH));

  assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_wr_req, seq_rd_req, seq_fetch}));

  assert_send_finishes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wr_req |=> (st_intr && !st_busy && op_idle));

  assert_last_with_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |-> seq_fetch);

  assert_last_finishes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |=> (st_intr && !st_busy && op_idle));

  assert_end_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |-> go);

  assert_derr_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && st_derr) |-> (!seq_wr_req && !seq_rd_req && !seq_fetch));

endmodule

bind smbb_xfer_buf smbb_xfer_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .go         (go),
  .st_derr    (st_derr),
  .st_intr    (st_intr),
  .st_busy    (st_busy),
  .op_idle    (op_idle),
  .seq_wr_req (seq_wr_req),
  .seq_rd_req (seq_rd_req),
  .seq_fetch  (seq_fetch),
  .seq_last   (seq_last),
  .seq_end    (seq_end),
  .idx_q      (idx_q)
);

// File: tb/smbb_xfer_buf_bench.sv
`timescale 1ns/1ps
module smbb_xfer_buf_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, buf_mode, last_byte, go, cnt_we, bd_wr, bd_rd, clr_en, fill_we, rd_done;
  logic [1:0] go_kind;
  logic [5:0] cnt_wdata, rd_count, cnt_q;
  logic [7:0] bd_wdata, bd_rdata, seq_fetch_data, fill_data, seq_rdata;
  logic [2:0] clr_mask;
  logic [4:0] fill_idx, seq_raddr;
  logic st_busy, st_intr, st_derr, st_bdone, op_idle;
  logic seq_wr_req, seq_rd_req, seq_fetch, seq_last, seq_end;

  smbb_xfer_buf u_smbb_xfer_buf (.*);

  int checks = 0, errors = 0;
  string cur_req = "R11";
  bit mem_known = 0, finished = 0;

  int m_buf[32];
  int m_idx, m_cnt, m_hold, fetch_ctr;
  bit m_busy, m_intr, m_derr, m_bd, m_opd, m_i2c, m_dir, m_rdw;
  int n_idx, n_cnt, n_hold, w_addr, w_data;
  bit n_busy, n_intr, n_derr, n_bd, n_opd, n_i2c, n_dir, n_rdw;
  bit e_wr, e_rd, e_fetch, e_last, e_end;
  int e_rdata;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_eval();
    int eff, step, adv;
    bit serial, clrbd, rdd;
    eff = (m_idx >= 32) ? 0 : m_idx;
    step = eff + 1;
    adv = (m_idx + 1 >= 32) ? 0 : m_idx + 1;
    serial = !m_opd && (m_i2c || !buf_mode);
    clrbd = clr_en && clr_mask[2] && m_bd;
    {n_idx, n_cnt, n_hold} = {m_idx, m_cnt, m_hold};
    {n_busy, n_intr, n_derr, n_bd} = {m_busy, m_intr, m_derr, m_bd};
    {n_opd, n_i2c, n_dir, n_rdw} = {m_opd, m_i2c, m_dir, m_rdw};
    {e_wr, e_rd, e_fetch, e_last, e_end} = '0;
    w_addr = -1; w_data = 0;
    e_rdata = (buf_mode && !m_i2c) ? m_buf[eff] : m_hold;
    if (clr_en) begin
      if (clr_mask[0]) n_intr = 0;
      if (clr_mask[1]) n_derr = 0;
      if (clr_mask[2]) n_bd = 0;
    end
    if (cnt_we) n_cnt = cnt_wdata;
    if (go) begin
      n_rdw = 0;
      n_dir = (go_kind != 0);
      if (!m_opd) begin
        n_idx = 0; n_opd = 1;
        if (m_i2c) begin n_i2c = 0; e_end = 1; end
      end
      if (!m_derr) begin
        if (go_kind == 0 && buf_mode) begin
          if ((m_opd ? m_idx : 0) != m_cnt) n_derr = 1;
          else begin e_wr = 1; n_opd = 1; n_intr = 1; n_busy = 0; end
          n_idx = 0;
        end else if (go_kind == 0) begin
          w_addr = 0; w_data = m_hold; n_idx = 0; n_opd = 0; n_busy = 1; n_bd = 1;
        end else if (go_kind == 1) begin
          e_rd = 1; n_rdw = 1; n_busy = 1;
        end else if (go_kind == 2) begin
          e_fetch = 1; n_hold = seq_fetch_data; n_i2c = 1; n_opd = 0; n_busy = 1; n_bd = 1;
        end else n_derr = 1;
      end
    end else if (rd_done && m_rdw) begin
      n_rdw = 0; n_cnt = rd_count; n_idx = 0; n_opd = 0;
      if (buf_mode) n_intr = 1; else begin n_hold = m_buf[0]; n_bd = 1; end
    end else if (clrbd && serial) begin
      rdd = m_i2c || m_dir;
      if (!rdd) begin
        n_idx = adv;
        if (adv == m_cnt) begin e_wr = 1; n_opd = 1; n_intr = 1; n_busy = 0; end
        else begin w_addr = adv; w_data = m_hold; n_bd = 1; end
      end else begin
        if (m_i2c) begin e_fetch = 1; n_hold = seq_fetch_data; end
        else n_hold = m_buf[adv];
        if (last_byte) begin
          e_last = m_i2c; n_i2c = 0; n_opd = 1; n_idx = 0; n_intr = 1; n_busy = 0;
        end else begin n_idx = adv; n_bd = 1; end
      end
    end else if (bd_wr) begin
      if (buf_mode) begin w_addr = eff; w_data = bd_wdata; n_idx = step; end
      else n_hold = bd_wdata;
    end else if (bd_rd && buf_mode && !m_i2c) begin
      n_idx = step;
      if (!m_opd && step == m_cnt) begin n_idx = 0; n_opd = 1; n_busy = 0; end
    end
  endtask

  task automatic compare();
    chk(cur_req, "busy", st_busy, m_busy);
    chk(cur_req, "intr", st_intr, m_intr);
    chk(cur_req, "derr", st_derr, m_derr);
    chk(cur_req, "bdone", st_bdone, m_bd);
    chk(cur_req, "op_idle", op_idle, m_opd);
    chk(cur_req, "count", cnt_q, m_cnt);
    chk(cur_req, "wr_req", seq_wr_req, e_wr);
    chk(cur_req, "rd_req", seq_rd_req, e_rd);
    chk(cur_req, "fetch", seq_fetch, e_fetch);
    chk(cur_req, "last", seq_last, e_last);
    chk(cur_req, "end", seq_end, e_end);
    if (mem_known) begin
      chk(cur_req, "bd_rdata", bd_rdata, e_rdata);
      chk(cur_req, "seq_rdata", seq_rdata, m_buf[seq_raddr]);
    end
  endtask

  task automatic tick();
    #1;
    model_eval();
    compare();
    @(posedge clk);
    {m_idx, m_cnt, m_hold} = {n_idx, n_cnt, n_hold};
    {m_busy, m_intr, m_derr, m_bd} = {n_busy, n_intr, n_derr, n_bd};
    {m_opd, m_i2c, m_dir, m_rdw} = {n_opd, n_i2c, n_dir, n_rdw};
    if (fill_we) m_buf[fill_idx] = fill_data;
    else if (w_addr >= 0) m_buf[w_addr] = w_data;
    if (e_fetch) fetch_ctr++;
    @(negedge clk);
    {go, cnt_we, bd_wr, bd_rd, clr_en, fill_we, rd_done, last_byte} = '0;
    seq_fetch_data = 8'hC0 + 8'(fetch_ctr);
  endtask

  task automatic do_go(int k); go = 1; go_kind = 2'(k); tick(); endtask
  task automatic do_cnt(int c); cnt_we = 1; cnt_wdata = 6'(c); tick(); endtask
  task automatic do_wr(int d); bd_wr = 1; bd_wdata = 8'(d); tick(); endtask
  task automatic do_clr(int m); clr_en = 1; clr_mask = 3'(m); tick(); endtask
  task automatic do_fill(int a, int d); fill_we = 1; fill_idx = 5'(a); fill_data = 8'(d); tick(); endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired during %s actual=hung expected=done", cur_req);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    {buf_mode, last_byte, go, cnt_we, bd_wr, bd_rd, clr_en, fill_we, rd_done} = '0;
    go_kind = 0; cnt_wdata = 0; rd_count = 0; bd_wdata = 0; fill_data = 0;
    clr_mask = 0; fill_idx = 0; seq_raddr = 0; seq_fetch_data = 8'hC0;
    m_idx = 0; m_cnt = 0; m_hold = 0; fetch_ctr = 0;
    {m_busy, m_intr, m_derr, m_bd, m_i2c, m_dir, m_rdw} = '0; m_opd = 1;
    for (int i = 0; i < 32; i++) m_buf[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    chk("R11", "reset status", {st_busy, st_intr, st_derr, st_bdone}, 0);
    chk("R11", "reset op_idle", op_idle, 1);
    chk("R11", "reset count", cnt_q, 0);
    chk("R11", "reset hold", bd_rdata, 0);
    for (int i = 0; i < 32; i++) do_fill(i, i * 3 + 1);
    mem_known = 1;
    // R1, R3: buffered write with matching count
    cur_req = "R1"; buf_mode = 1;
    do_cnt(3); do_wr(8'h11); do_wr(8'h22); do_wr(8'h33);
    seq_raddr = 1; #1 chk("R1", "entry1", seq_rdata, 8'h22);
    cur_req = "R3"; do_go(0);
    chk("R3", "intr after send", st_intr, 1);
    do_clr(1);
    // R3 mismatch, R9 blocked start
    do_cnt(4); do_wr(8'h44); do_wr(8'h55); do_go(0);
    chk("R3", "derr on mismatch", st_derr, 1);
    cur_req = "R9"; do_go(1); do_go(2); do_clr(2);
    // R2: full 32 block then wrap
    cur_req = "R2"; do_cnt(32);
    for (int i = 0; i < 32; i++) do_wr(8'h80 + i);
    do_go(0);
    chk("R2", "full block no derr", st_derr, 0);
    do_clr(1);
    for (int i = 0; i < 33; i++) do_wr(8'h40 + i);
    seq_raddr = 0; #1 chk("R2", "33rd wraps to 0", seq_rdata, 8'h60);
    do_go(0); chk("R2", "idx 1 vs 32", st_derr, 1); do_clr(2);
    // R12: bad kind
    cur_req = "R12"; do_go(3); chk("R12", "bad kind derr", st_derr, 1); do_clr(2);
    // R4: buffered read
    cur_req = "R4"; do_go(1);
    do_fill(0, 8'hA1); do_fill(1, 8'hA2); do_fill(2, 8'hA3);
    rd_done = 1; rd_count = 3; tick();
    for (int i = 0; i < 3; i++) begin
      #1 chk("R4", "read byte", bd_rdata, 8'hA1 + i);
      bd_rd = 1; tick();
    end
    chk("R4", "busy clear after last", st_busy, 0);
    do_clr(1);
    // R1 byte-mode hold
    cur_req = "R1"; buf_mode = 0; do_wr(8'h5A);
    #1 chk("R1", "hold readback", bd_rdata, 8'h5A);
    // R10: clearing byte-done while idle does nothing
    cur_req = "R10"; do_clr(4); do_clr(7);
    // R5, R6: byte-mode write of 3
    cur_req = "R6"; do_cnt(3); do_wr(8'h11); do_go(0);
    seq_raddr = 0; #1 chk("R5", "entry0 from hold", seq_rdata, 8'h11);
    do_wr(8'h22); do_clr(4); do_wr(8'h33); do_clr(4);
    seq_raddr = 2; #1 chk("R6", "entry2", seq_rdata, 8'h33);
    do_clr(4); chk("R6", "send done intr", st_intr, 1); do_clr(1);
    // R7: byte-mode block read, last byte
    cur_req = "R7"; do_go(1); do_fill(0, 8'hB0); do_fill(1, 8'hB1); do_fill(2, 8'hB2);
    rd_done = 1; rd_count = 3; tick();
    #1 chk("R5", "first byte in hold", bd_rdata, 8'hB0);
    do_clr(4); last_byte = 1; do_clr(4);
    chk("R7", "last read byte", bd_rdata, 8'hB2); do_clr(1);
    // R7: I2C block read with NACK/stop
    do_go(2); do_clr(4); last_byte = 1; do_clr(4);
    chk("R7", "i2c done", st_busy, 0); do_clr(1);
    // R8: start during open I2C read
    cur_req = "R8"; do_go(2); do_clr(4); do_go(0);
    chk("R8", "restart busy", st_busy, 1);
    buf_mode = 1; do_go(1);
    do_clr(7); buf_mode = 0; do_clr(7);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule